// File: doc/BRIEF.md
# Coin-Operated Sale Controller with Change Return

This block is a synchronous state machine for a single-price sales point. On every clock edge it samples one coin slot input that names either no coin, a five-unit coin, a ten-unit coin or a twenty-five-unit coin. It keeps a running credit for the sale in progress. When the credit plus the incoming coin meets or exceeds the price of 20, it raises a one-cycle sale pulse. In that same cycle it reports the overpayment as a change amount. It then starts the next sale from zero credit.

Credit is held in whole multiples of the smallest coin, so the default build keeps just four credit levels (0, 5, 10, 15) in two flip-flops. A coin that would reach the price never lands in the credit register: it settles the sale directly.

The design splits into a datapath and a control machine. The datapath holds the credit and change registers and the adder. The control machine decides each cycle whether to accumulate or to settle, and it registers the sale pulse.

Top module: `vend_controller`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the credit to 0. It also drives vend and change to 0 from the following cycle.
- R2: The coin input code adds value to the credit. 2'b01 adds 5, 2'b10 adds 10 and 2'b11 adds 25.
- R3: Coin code 2'b00 means no coin. It leaves the credit unchanged and never causes a sale.
- R4: vend is high for exactly the one cycle after the clock edge at which credit plus the sampled coin reaches 20 or more. It is low otherwise.
- R5: In the cycle vend is high, the change port carries (credit + coin - 20) / 5. The port value is 0, 1, 2, 3 or 4 for 0, 5, 10, 15 or 20 returned.
- R6: change is 0 in every cycle in which vend is low.
- R7: After a sale the credit is 0, so the next sale starts from nothing.
- R8: While credit plus coin stays below 20, the value accumulates and vend stays low. For example, three five-unit coins give credit 15 with no sale.
- R9: The corner outcomes hold. Credit 15 plus 10 gives change port 1. Credit 0 plus 25 gives change port 1. Credit 15 plus 25 gives change port 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coinCode | input | 2 | Coin sampled this edge: 00 none, 01 five, 10 ten, 11 twenty-five |
| vend | output | 1 | One-cycle sale pulse |
| change | output | 3 | Change returned in units of 5, valid while vend is high |

## Verification
The bench builds the block with its default parameters. These are a coin unit of 5, a price of 20 and coin values 5, 10 and 25. With them, all four credit levels are reachable, and so is the full change range from 0 up to the maximum of 20 that only credit 15 plus a twenty-five-unit coin produces. Seeded random coin streams with frequent idle cycles give back-to-back sales, long idle holds and a reset in the middle of a sale. Directed sequences pin down each corner outcome.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    COIN_NONE    = 2'b00,
    COIN_SMALL   = 2'b01,
    COIN_MID     = 2'b10,
    COIN_LARGE   = 2'b11
  } coin_e;

  // Strobes from the control machine to the datapath.
  typedef struct packed {
    logic takeSum;   // store credit + coin as the new credit
    logic settle;    // close the sale: clear credit, latch change
  } dp_ctrl_t;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_VEND    = 1'b1
  } vend_state_e;

endpackage

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
#(
  parameter int UNIT       = 5,
  parameter int PRICE      = 20,
  parameter int SMALL_VAL  = 5,
  parameter int MID_VAL    = 10,
  parameter int LARGE_VAL  = 25,
  parameter int CREDIT_W   = 2,
  parameter int SUM_W      = 4,
  parameter int CHANGE_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          coinCode,
  input  dp_ctrl_t            ctrlS,
  output logic                coinValid,
  output logic                reachPrice,
  output logic [CREDIT_W-1:0] creditQ,
  output logic [CHANGE_W-1:0] changeQ
);

  localparam int PRICE_UNITS = PRICE / UNIT;

  // Coin value table in units of the smallest coin, built per code.
  logic [SUM_W-1:0] coinLut [4];

  for (genvar g = 0; g < 4; g++) begin : g_lut
    localparam int VAL = (g == 1) ? SMALL_VAL :
                         (g == 2) ? MID_VAL   :
                         (g == 3) ? LARGE_VAL : 0;
    assign coinLut[g] = SUM_W'(VAL / UNIT);
  end

  logic [SUM_W-1:0] sumUnits;
  logic [SUM_W-1:0] excessUnits;

  always_comb begin
    sumUnits    = {{(SUM_W-CREDIT_W){1'b0}}, creditQ} + coinLut[coinCode];
    excessUnits = sumUnits - SUM_W'(PRICE_UNITS);
    coinValid   = (coinCode != COIN_NONE);
    reachPrice  = (sumUnits >= SUM_W'(PRICE_UNITS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      creditQ <= '0;
      changeQ <= '0;
    end else if (ctrlS.settle) begin
      creditQ <= '0;
      changeQ <= excessUnits[CHANGE_W-1:0];
    end else if (ctrlS.takeSum) begin
      creditQ <= sumUnits[CREDIT_W-1:0];
      changeQ <= '0;
    end else begin
      changeQ <= '0;
    end
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     coinValid,
  input  logic     reachPrice,
  output dp_ctrl_t ctrlS,
  output logic     vendQ
);

  vend_state_e stateQ, stateD;

  always_comb begin
    ctrlS.takeSum = coinValid && !reachPrice;
    ctrlS.settle  = coinValid && reachPrice;
    stateD        = ctrlS.settle ? ST_VEND : ST_COLLECT;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_COLLECT;
    else     stateQ <= stateD;
  end

  assign vendQ = (stateQ == ST_VEND);

endmodule

// File: rtl/vend_controller.sv
module vend_controller
  import vend_pkg::*;
#(
  parameter int UNIT      = 5,
  parameter int PRICE     = 20,
  parameter int SMALL_VAL = 5,
  parameter int MID_VAL   = 10,
  parameter int LARGE_VAL = 25,
  localparam int PRICE_UNITS = PRICE / UNIT,
  localparam int CREDIT_W    = (PRICE_UNITS > 2) ? $clog2(PRICE_UNITS) : 1,
  localparam int MAX_SUM     = PRICE_UNITS - 1 + LARGE_VAL / UNIT,
  localparam int SUM_W       = $clog2(MAX_SUM + 1),
  localparam int MAX_CHANGE  = MAX_SUM - PRICE_UNITS,
  localparam int CHANGE_W    = (MAX_CHANGE > 1) ? $clog2(MAX_CHANGE + 1) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          coinCode,
  output logic                vend,
  output logic [CHANGE_W-1:0] change
);

  dp_ctrl_t            ctrlS;
  logic                coinValid;
  logic                reachPrice;
  logic [CREDIT_W-1:0] creditQ;

  vend_datapath #(
    .UNIT(UNIT), .PRICE(PRICE),
    .SMALL_VAL(SMALL_VAL), .MID_VAL(MID_VAL), .LARGE_VAL(LARGE_VAL),
    .CREDIT_W(CREDIT_W), .SUM_W(SUM_W), .CHANGE_W(CHANGE_W)
  ) dp_i (
    .clk(clk), .rst(rst), .coinCode(coinCode), .ctrlS(ctrlS),
    .coinValid(coinValid), .reachPrice(reachPrice),
    .creditQ(creditQ), .changeQ(change)
  );

  vend_ctrl ctrl_i (
    .clk(clk), .rst(rst), .coinValid(coinValid), .reachPrice(reachPrice),
    .ctrlS(ctrlS), .vendQ(vend)
  );

endmodule

// File: rtl/vend_checker.sv
module vend_checker #(
  parameter int CREDIT_W   = 2,
  parameter int CHANGE_W   = 3,
  parameter int MAX_CHANGE = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          coinCode,
  input logic                vend,
  input logic [CHANGE_W-1:0] change,
  input logic [CREDIT_W-1:0] creditQ
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!vend && change == '0 && creditQ == '0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (coinCode == 2'b00) |=> (creditQ == $past(creditQ) && !vend));

  p_vend_needs_coin_r4: assert property (@(posedge clk) disable iff (rst)
    vend |-> ($past(coinCode) != 2'b00));

  p_change_range_r5: assert property (@(posedge clk) disable iff (rst)
    vend |-> (int'(change) <= MAX_CHANGE));

  p_change_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !vend |-> (change == '0));

  p_credit_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    vend |-> (creditQ == '0));

endmodule

bind vend_controller vend_checker #(
  .CREDIT_W(CREDIT_W), .CHANGE_W(CHANGE_W), .MAX_CHANGE(MAX_CHANGE)
) chk_i (
  .clk(clk), .rst(rst), .coinCode(coinCode),
  .vend(vend), .change(change), .creditQ(creditQ)
);

// File: tb/vend_controller_tb_top.sv
module vend_controller_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] coinCode = 2'b00;
  logic       vend;
  logic [2:0] change;

  int checks = 0;
  int failures = 0;
  int modelCredit = 0;   // in units of 5
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  vend_controller dut_i (
    .clk(clk), .rst(rst), .coinCode(coinCode), .vend(vend), .change(change)
  );

  function automatic int unitsOf(input logic [1:0] code);
    case (code)
      2'b01:   return 1;
      2'b10:   return 2;
      2'b11:   return 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit expVendOf(input int credit, input logic [1:0] code);
    return (credit + unitsOf(code)) >= 4;
  endfunction

  function automatic int expChangeOf(input int credit, input logic [1:0] code);
    return expVendOf(credit, code) ? credit + unitsOf(code) - 4 : 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d credit=%0d", tag, act, exp, modelCredit);
    end
  endtask

  // Called at a negedge; drives one coin, checks the result one edge later.
  task automatic step(input logic [1:0] code, input string tag);
    bit ev;
    int ec;
    ev = expVendOf(modelCredit, code);
    ec = expChangeOf(modelCredit, code);
    coinCode = code;
    @(posedge clk);
    @(negedge clk);
    coinCode = 2'b00;
    check({tag, " vend"}, int'(vend), int'(ev));
    check({tag, " change"}, int'(change), ec);
    modelCredit = ev ? 0 : modelCredit + unitsOf(code);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset vend", int'(vend), 0);
    check("R1 reset change", int'(change), 0);
    rst = 1'b0;

    // R9: credit 0 plus quarter
    step(2'b11, "R9 zero+quarter");
    // R8 accumulate to 15, then R9 15 + dime
    step(2'b01, "R8 nickel1");
    step(2'b01, "R8 nickel2");
    step(2'b01, "R8 nickel3");
    step(2'b10, "R9 fifteen+dime");
    // R9 15 + quarter -> change 4
    step(2'b10, "R2 dime");
    step(2'b01, "R2 nickel");
    step(2'b11, "R9 fifteen+quarter");
    // R3 idle hold: 10 held across idles, then dime+dime
    step(2'b10, "R2 dime");
    step(2'b00, "R3 idle1");
    step(2'b00, "R3 idle2");
    step(2'b00, "R3 idle3");
    step(2'b10, "R3 held credit");
    // R7: back-to-back sales start from zero
    step(2'b11, "R7 sale1");
    step(2'b11, "R7 sale2");
    step(2'b10, "R7 after sale");
    step(2'b10, "R7 exact");

    // R1 mid-sale reset clears credit
    step(2'b01, "R2 nickel");
    step(2'b10, "R2 dime");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelCredit = 0;
    check("R1 midreset vend", int'(vend), 0);
    check("R1 midreset change", int'(change), 0);
    step(2'b10, "R1 after reset");
    step(2'b10, "R1 after reset exact");

    // Seeded random stream with frequent idles
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] c;
      int r;
      r = int'($urandom_range(0, 9));
      c = (r < 3) ? 2'b00 : (r < 6) ? 2'b01 : (r < 8) ? 2'b10 : 2'b11;
      step(c, (c == 2'b00) ? "R3 rand" : "R2 rand");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule